// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block gathers the interrupt events of a serial port (line error, received data, receive timeout, transmit holding empty, modem line change and one auxiliary source) into six latched pending flags. It masks them through a software-written enable register and drives a single interrupt line to the processor. A status register reports only the most urgent enabled pending level as a small code. Reading that register services the reported level.

The processor reaches the block through a plain register port with an address, a write strobe, a read strobe and byte-wide data. Read data is registered and appears after the clock edge that samples the read strobe. The block does not hold the data register itself. It only watches accesses to that address, because a read there services the received-data level and a write there services the transmit-empty level. Event inputs are one-cycle pulses. Every pending flag is sticky until its own clearing action occurs, so events that arrive while a higher level is being serviced are kept and reported later.

An internal state machine has three states. ST_QUIET means nothing enabled is pending. ST_RAISED means an enabled level is pending. ST_SERVICE means a status read has reported received data, which a status read does not clear.
- QUIET to RAISED: an enabled level becomes pending.
- RAISED to SERVICE: a status read reports received data.
- SERVICE to RAISED: received data is cleared while other enabled levels remain.
- Any state to QUIET: no enabled level remains pending.

The interrupt line is high in every state except ST_QUIET.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the interrupt line is low, a status read returns 0x01 and an enable read returns 0x00.
- R2: A write to address 1 sets the enable register from wr_data[4:0]; reading address 1 returns those five bits with bits 7:5 zero.
- R3: Levels rank from most to least urgent: line error (code 0x02), received data (0x04), receive timeout (0x06), transmit holding empty (0x08), modem change (0x0A), auxiliary (0x0C). A status read at address 2 returns only the code of the most urgent enabled pending level.
- R4: A status read with no enabled pending level returns 0x01 (bit 0 set means nothing pending).
- R5: A status read clears the reported level when it is line error, timeout, transmit empty, modem or auxiliary. It leaves all other levels pending, and the next status read reports them.
- R6: A status read does not clear received data; it stays reported, and every less urgent level stays hidden, until a read at address 0 clears it.
- R7: A write to address 0 clears a pending transmit-empty level.
- R8: Enable bit 0 gates received data and timeout, bit 1 transmit empty, bit 2 line error, bit 3 modem change and bit 4 auxiliary. A masked level neither raises the interrupt nor is reported, but stays latched and appears once enabled.
- R9: The interrupt line is high, from the clock edge that latches an event, exactly while some enabled level is pending.
- R10: An event arriving in the same cycle as a clearing action for its own level leaves that level pending.
- R11: A pending level stays latched over idle cycles until its clearing action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address (0 data, 1 enable, 2 status) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |
| ev_line_err | input | 1 | Receive character error pulse |
| ev_rx_data | input | 1 | Received data available pulse |
| ev_rx_timeout | input | 1 | Character timeout pulse |
| ev_tx_empty | input | 1 | Transmit holding empty pulse |
| ev_modem | input | 1 | Modem input change pulse |
| ev_aux | input | 1 | Auxiliary source pulse |
| irq | output | 1 | Interrupt to the processor |

## Verification
The hardest case to reach is a collision: a status read and a fresh event for the very level being reported, landing on the same clock edge. The bench drives the event pulse and the read strobe in the same cycle, then reads twice more to show that the level survived. A second hard case is a received-data level that holds back a full stack of lower levels. The stimulus raises all six sources in one cycle and repeats status reads before and after the data-address read, so the codes must unwind strictly in rank order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NLVL  = 6;
    localparam int IDX_W = $clog2(NLVL);
    localparam int EN_W  = 5;

    // level indices, 0 is most urgent
    localparam int LV_ERR   = 0;
    localparam int LV_RX    = 1;
    localparam int LV_TMO   = 2;
    localparam int LV_THR   = 3;
    localparam int LV_MODEM = 4;
    localparam int LV_AUX   = 5;

    // enable register bit positions
    localparam int EB_RX    = 0;
    localparam int EB_THR   = 1;
    localparam int EB_ERR   = 2;
    localparam int EB_MODEM = 3;
    localparam int EB_AUX   = 4;

    // levels that a status read services (received data is not one)
    localparam logic [NLVL-1:0] CLR_ON_STAT = 6'b111101;

    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_RAISED  = 2'd1,
        ST_SERVICE = 2'd2
    } irq_state_e;

    function automatic logic [NLVL-1:0] lvl_mask(input logic [EN_W-1:0] en);
        logic [NLVL-1:0] m;
        m           = '0;
        m[LV_ERR]   = en[EB_ERR];
        m[LV_RX]    = en[EB_RX];
        m[LV_TMO]   = en[EB_RX];
        m[LV_THR]   = en[EB_THR];
        m[LV_MODEM] = en[EB_MODEM];
        m[LV_AUX]   = en[EB_AUX];
        return m;
    endfunction

endpackage

// File: rtl/irqc_pend.sv
module irqc_pend
    import irqc_pkg::*;
#(
    parameter int N = NLVL,
    parameter logic [N-1:0] STAT_CLR = CLR_ON_STAT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] stat_sel_i,
    input  logic [N-1:0] ext_clr_i,
    output logic [N-1:0] pend_q,
    output logic [N-1:0] pend_d
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic clr_now;
        assign clr_now   = ext_clr_i[i] | (stat_sel_i[i] & STAT_CLR[i]);
        // a new event outranks a clear arriving in the same cycle
        assign pend_d[i] = set_i[i] | (pend_q[i] & ~clr_now);

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[i] <= 1'b0;
            end else begin
                pend_q[i] <= pend_d[i];
            end
        end
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N = 6,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          vld_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  oh_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
        vld_o = |req_i;
        oh_o  = '0;
        if (vld_o) begin
            oh_o[idx_o] = 1'b1;
        end
    end

endmodule

// File: rtl/irqc_fsm.sv
module irqc_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic any_d_i,
    input  logic stat_rx_i,
    input  logic rx_live_d_i,
    output logic irq_o,
    output irq_state_e state_o
);

    irq_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (any_d_i) state_n = ST_RAISED;
            end
            ST_RAISED: begin
                if (!any_d_i)       state_n = ST_QUIET;
                else if (stat_rx_i) state_n = ST_SERVICE;
            end
            ST_SERVICE: begin
                if (!any_d_i)          state_n = ST_QUIET;
                else if (!rx_live_d_i) state_n = ST_RAISED;
            end
            default: state_n = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        irq_o   = (state_q != ST_QUIET);
        state_o = state_q;
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_line_err,
    input  logic              ev_rx_data,
    input  logic              ev_rx_timeout,
    input  logic              ev_tx_empty,
    input  logic              ev_modem,
    input  logic              ev_aux,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
    localparam logic [DATA_W-1:0] NONE_CODE = DATA_W'(1);

    logic [EN_W-1:0]   en_q, en_n;
    logic [NLVL-1:0]   ev_vec, pend_q, pend_d;
    logic [NLVL-1:0]   lvl_en_q, lvl_en_d, live_q;
    logic [NLVL-1:0]   stat_sel, ext_clr, rep_oh;
    logic [IDX_W-1:0]  rep_idx;
    logic              rep_vld, stat_rd, stat_rx, any_d, rx_live_d;
    logic [DATA_W-1:0] stat_val, rd_mux, rd_q;
    irq_state_e        fsm_state;

    assign ev_vec = {ev_aux, ev_modem, ev_tx_empty, ev_rx_timeout, ev_rx_data, ev_line_err};

    // enable register
    assign en_n = (wr_en && addr == A_EN) ? wr_data[EN_W-1:0] : en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= en_n;
        end
    end

    assign lvl_en_q = lvl_mask(en_q);
    assign lvl_en_d = lvl_mask(en_n);
    assign live_q   = pend_q & lvl_en_q;

    irqc_prio #(.N(NLVL)) u_prio (
        .req_i (live_q),
        .vld_o (rep_vld),
        .idx_o (rep_idx),
        .oh_o  (rep_oh)
    );

    assign stat_rd  = rd_en && (addr == A_STAT);
    assign stat_sel = stat_rd ? rep_oh : '0;
    assign stat_rx  = stat_rd && rep_vld && (rep_idx == IDX_W'(LV_RX));

    always_comb begin
        ext_clr         = '0;
        ext_clr[LV_RX]  = rd_en && (addr == A_DATA);
        ext_clr[LV_THR] = wr_en && (addr == A_DATA);
    end

    irqc_pend #(.N(NLVL), .STAT_CLR(CLR_ON_STAT)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .set_i      (ev_vec),
        .stat_sel_i (stat_sel),
        .ext_clr_i  (ext_clr),
        .pend_q     (pend_q),
        .pend_d     (pend_d)
    );

    assign any_d     = |(pend_d & lvl_en_d);
    assign rx_live_d = pend_d[LV_RX] & lvl_en_d[LV_RX];

    irqc_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .any_d_i     (any_d),
        .stat_rx_i   (stat_rx),
        .rx_live_d_i (rx_live_d),
        .irq_o       (irq),
        .state_o     (fsm_state)
    );

    // status code: level index plus one in bits IDX_W:1, bit 0 flags none
    always_comb begin
        stat_val = NONE_CODE;
        if (rep_vld) begin
            stat_val = '0;
            stat_val[IDX_W:1] = rep_idx + IDX_W'(1);
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            A_EN:    rd_mux[EN_W-1:0] = en_q;
            A_STAT:  rd_mux = stat_val;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_mux;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq,
    input logic [5:0]        pend_q,
    input logic [4:0]        en_q
);

    AST_NONE_CODE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(2) && !irq) |=> rd_data == DATA_W'(1)); // R4

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(2)) |=>
            (rd_data == DATA_W'(1)) ||
            (rd_data[0] == 1'b0 && rd_data[3:1] != 3'd0 && rd_data[3:1] <= 3'd6 &&
             rd_data[DATA_W-1:4] == '0)); // R3

    AST_ERR_FIRST: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(2) && pend_q[0] && en_q[2]) |=> rd_data == DATA_W'(2)); // R3

    AST_PEND_SEEN: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(2) && irq) |=> !rd_data[0]); // R9

    AST_MASK_ALL: assert property (@(posedge clk) disable iff (rst)
        (en_q == 5'd0) |-> !irq); // R8

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(2) && pend_q[1] && en_q[0]) |=>
            (rd_data == DATA_W'(2) || rd_data == DATA_W'(4))); // R6

    AST_EN_READBACK: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(1)) ##1 (rd_en && !wr_en && addr == ADDR_W'(1)) |=>
            (rd_data[4:0] == $past(wr_data[4:0], 2) && rd_data[DATA_W-1:5] == '0)); // R2

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .irq     (irq),
    .pend_q  (pend_q),
    .en_q    (en_q)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [5:0] ev = '0;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    uart_irq_ctrl u_dut (
        .clk           (clk),
        .rst           (rst),
        .addr          (addr),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_en         (rd_en),
        .rd_data       (rd_data),
        .ev_line_err   (ev[0]),
        .ev_rx_data    (ev[1]),
        .ev_rx_timeout (ev[2]),
        .ev_tx_empty   (ev[3]),
        .ev_modem      (ev[4]),
        .ev_aux        (ev[5]),
        .irq           (irq)
    );

    // monitor: a read sampled at an edge is compared just after that edge
    initial begin
        forever begin
            logic fire;
            @(posedge clk);
            fire = rd_en && !rst;
            #2;
            if (fire) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL scoreboard: read with no expectation, actual=%02h", rd_data);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (rd_data !== e) begin
                        failures++;
                        $display("FAIL %s: rd_data actual=%02h expected=%02h", t, rd_data, e);
                    end
                end
            end
        end
    end

    task automatic check_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            failures++;
            $display("FAIL %s: irq actual=%0b expected=%0b", t, irq, e);
        end
    endtask

    task automatic do_read(input logic [1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] v);
        @(negedge clk);
        ev = v;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_irq(1'b0, "R1 irq after reset");
        do_read(2'd2, 8'h01, "R1 status after reset");
        do_read(2'd1, 8'h00, "R1 enable after reset");

        // R8: masked error latched but silent
        pulse(6'b000001);
        check_irq(1'b0, "R8 masked error irq");
        do_read(2'd2, 8'h01, "R8 masked error status");
        // R2: enable write and readback
        do_write(2'd1, 8'hFF);
        do_read(2'd1, 8'h1F, "R2 enable readback");
        check_irq(1'b1, "R8 latched error appears once enabled");
        do_read(2'd2, 8'h02, "R3 error code");
        check_irq(1'b0, "R5 error cleared by status read");

        // R3/R5/R6: all six at once unwind in rank order
        pulse(6'b111111);
        check_irq(1'b1, "R9 irq after events");
        do_read(2'd2, 8'h02, "R3 error first");
        do_read(2'd2, 8'h04, "R3 rx data second");
        do_read(2'd2, 8'h04, "R6 rx data held, lower hidden");
        do_read(2'd0, 8'h00, "R6 data read");
        do_read(2'd2, 8'h06, "R5 timeout next");
        do_read(2'd2, 8'h08, "R5 tx empty next");
        do_read(2'd2, 8'h0A, "R5 modem next");
        do_read(2'd2, 8'h0C, "R5 aux last");
        do_read(2'd2, 8'h01, "R4 none left");
        check_irq(1'b0, "R9 irq low when drained");

        // R7: transmit empty cleared by data write
        pulse(6'b001000);
        check_irq(1'b1, "R7 tx empty raises irq");
        do_write(2'd0, 8'h55);
        check_irq(1'b0, "R7 tx empty cleared by data write");
        do_read(2'd2, 8'h01, "R7 status after data write");

        // R10: event and status read on same edge
        pulse(6'b010000);
        @(negedge clk);
        addr = 2'd2; rd_en = 1'b1; ev = 6'b010000;
        exp_q.push_back(8'h0A); tag_q.push_back("R10 modem reported");
        @(negedge clk);
        rd_en = 1'b0; ev = '0;
        do_read(2'd2, 8'h0A, "R10 modem survives collision");
        do_read(2'd2, 8'h01, "R10 modem then cleared");

        // R11: sticky over idle cycles
        pulse(6'b000100);
        idle(20);
        check_irq(1'b1, "R11 timeout still raising irq");
        do_read(2'd2, 8'h06, "R11 timeout still pending");

        // R8: per-bit mask of transmit empty
        do_write(2'd1, 8'h1D);
        pulse(6'b001000);
        check_irq(1'b0, "R8 tx empty masked irq");
        do_read(2'd2, 8'h01, "R8 tx empty masked status");
        do_write(2'd1, 8'h1F);
        do_read(2'd2, 8'h08, "R8 tx empty after unmask");

        // R3/R8: modem masked, aux reported
        do_write(2'd1, 8'h10);
        pulse(6'b110000);
        do_read(2'd2, 8'h0C, "R8 aux only enabled");
        do_read(2'd2, 8'h01, "R8 modem still masked");
        check_irq(1'b0, "R8 irq with modem masked");
        do_write(2'd1, 8'h08);
        check_irq(1'b1, "R8 modem irq once enabled");
        do_read(2'd2, 8'h0A, "R8 modem reported once enabled");

        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: %0d reads unchecked, expected 0", exp_q.size());
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule